// File: doc/BRIEF.md
# Sequenced I2C Configuration Write Port

This block is a write-only I2C target that loads the settings of a frequency-synthesizer loop: a 15-bit main division ratio, a 2-bit reference-divider select, loop-amplifier and charge-pump controls, doubler controls and six general switch lines. A host sends the block's address byte, then a run of data bytes in a fixed order. The divider group has three bytes and the control group has three bytes. Each byte lands in a shadow copy. The live outputs change only when the stop condition closes a transfer that had no error.

The first data byte after the address names the group by its top bit. Every later byte is decoded by its place in the run. If a byte breaks the allowed order, the block refuses it with no acknowledge, and the whole transfer is dropped. Two address-select inputs pick one of four target addresses. The block samples SCL and SDA with the system clock and only pulls SDA low, for acknowledges.

Top module: `tcfg_i2c_regs`

## Requirements
- R1: Only the address byte `1100_0`,`addr_sel[1]`,`addr_sel[0]`,`0` is acknowledged. Any other address, including one with the read bit (bit 0) set, gets no acknowledge and leaves every output unchanged.
- R2: Divider bytes map onto the outputs as follows. In byte one, bit 7 is 0, bits 6:5 go to `ref_sel[1:0]` and bits 2:0 go to `ratio[14:12]`. Bits 5:0 of byte two go to `ratio[11:6]`. Bits 5:0 of byte three go to `ratio[5:0]`.
- R3: Control byte one has bit 7 set and bit 5 clear. Its bit 4 drives `loop_off`, bit 3 `test_en`, bit 2 `pump_off`, and bits 1:0 `pump_cur[1:0]`.
- R4: In control byte two, bit 7 drives `dbl_off`, bit 6 `dbl_boost` and bits 5:0 `sw_out[5:0]`.
- R5: Outputs stay unchanged while a transfer is in progress. After a stop that ends a valid transfer, the new values appear together with a `commit` pulse exactly one cycle wide. A transfer that stages nothing gives no pulse.
- R6: The first data byte selects divider byte one if bit 7 is 0 and control byte one if bit 7 is 1. Every later byte is taken by position, so a byte with bit 7 set that follows divider byte one is loaded as divider byte two.
- R7: A transfer that stops early updates only the fields of the bytes it delivered.
- R8: After divider byte three, only a control byte one (bit 7 set) may follow. Any other byte there gets no acknowledge and voids the whole transfer.
- R9: Any of the following gets no acknowledge and voids the transfer: a control byte one with bit 5 set, a control byte three whose bits 6:0 are not all zero, or any byte after control byte three.
- R10: Every accepted byte is acknowledged by driving `sda_oe` high during the ninth SCL clock.
- R11: After reset all configuration outputs are 0, `commit` is 0 and SDA is released.
- R12: A repeated start discards whatever the interrupted part of the transfer staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 2 | Chooses one of four target addresses |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| ratio | output | 15 | Main division ratio |
| ref_sel | output | 2 | Reference-divider select |
| loop_off | output | 1 | Loop amplifier off |
| test_en | output | 1 | Divider test monitoring enable |
| pump_off | output | 1 | Charge pump off |
| pump_cur | output | 2 | Charge-pump current code |
| dbl_off | output | 1 | Frequency doubler off |
| dbl_boost | output | 1 | Doubler drive boost |
| sw_out | output | 6 | General switch lines |
| commit | output | 1 | One-cycle pulse when new values take effect |

## Verification
The main function is tried with several transfers:
- A full divider run shows that the bit fields land in the right ratio segments.
- A control-only run shows that the ratio is left alone.
- A short run checks partial updates.
- A full six-byte run checks the longest legal order.

Illegal orders are placed at each point where they can occur: after divider byte three, inside control byte one, in control byte three, and past the end. Each one shows that the refusal lands on the right byte and that nothing is committed. A divider byte one followed by a byte with its top bit set shows decoding by position rather than by content. Held-off stops, repeated starts and a change of address select separate the commit timing from the acknowledge behaviour.

// File: rtl/tcfg_pkg.sv
// Shared widths, the staged-configuration record and the sequence positions
// used by the I2C configuration write port.
package tcfg_pkg;
    parameter int BYTE_W  = 8;
    parameter int RATIO_W = 15;
    parameter int SEG_W   = 6;
    parameter int CUR_W   = 2;
    parameter int SW_N    = 6;
    localparam int HI_W   = RATIO_W - 2 * SEG_W;
    localparam int GRP_N  = 5;
    localparam int G_D1   = 0;
    localparam int G_D2   = 1;
    localparam int G_D3   = 2;
    localparam int G_C1   = 3;
    localparam int G_C2   = 4;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [1:0]         ref_sel;
        logic               loop_off;
        logic               test_en;
        logic               pump_off;
        logic [CUR_W-1:0]   pump_cur;
        logic               dbl_off;
        logic               dbl_boost;
        logic [SW_N-1:0]    sw;
    } cfg_t;

    typedef enum logic [3:0] {
        P_IDLE, P_ADDR, P_FIRST, P_D2, P_D3, P_C1, P_C2, P_C3, P_END
    } pos_e;
endpackage

// File: rtl/tcfg_line_sync.sv
// Brings SCL and SDA into the clock domain through a flop chain and derives
// clock edges plus start/stop conditions (SDA edge while SCL is high).
// Assumes the system clock is many times faster than SCL.
module tcfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d, scl_s;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: one-flop sampling when a single stage is requested.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff[0] <= scl_i;
                    sda_ff[0] <= sda_i;
                end
            end
        end else begin : g_chain
            // Purpose: shift both lines through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    // Purpose: keep last synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tcfg_byte_rx.sv
// Shifts in bytes MSB first on SCL rising edges, pulses byte_stb after the
// eighth bit and drives the ninth-bit acknowledge when the sequencer accepts.
// After a refused byte it stays silent until the next start condition.
module tcfg_byte_rx
    import tcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              accept,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(BYTE_W);
    typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_HOLD, RX_ACK} rx_e;

    rx_e              st;
    logic [CNT_W-1:0] cnt;
    logic [BYTE_W-1:0] sh;

    // Purpose: bit shifting, byte framing and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RX_IDLE;
            cnt      <= '0;
            sh       <= '0;
            byte_stb <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (stop_det) begin
                st     <= RX_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                st     <= RX_BITS;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    RX_BITS: if (scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            byte_stb <= 1'b1;
                            st       <= RX_HOLD;
                        end
                    end
                    RX_HOLD: if (scl_fall) begin
                        if (accept) begin
                            sda_oe <= 1'b1;
                            st     <= RX_ACK;
                        end else begin
                            st <= RX_IDLE;
                        end
                    end
                    RX_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        st     <= RX_BITS;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign byte_val = sh;

    // R10: acknowledge only for a byte the sequencer accepted
    a_r10_ack_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> accept);
    // R10: acknowledge starts right after SCL falls
    a_r10_ack_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
endmodule

// File: rtl/tcfg_frame_seq.sv
// Tracks the byte position inside a transfer, checks the address and the
// allowed byte order, stages fields with a per-group written mask and
// raises commit at stop when the transfer was not voided.
module tcfg_frame_seq
    import tcfg_pkg::*;
#(
    parameter logic [4:0] ADDR_BASE = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [1:0]        addr_sel,
    output logic              accept,
    output cfg_t              stage,
    output logic [GRP_N-1:0]  wmask,
    output logic              commit
);
    pos_e pos;
    logic void_q;
    logic addr_ok;

    assign addr_ok = (byte_val == {ADDR_BASE, addr_sel, 1'b0});

    // Purpose: position tracking, order checks, staging and commit request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= P_IDLE;
            void_q <= 1'b1;
            accept <= 1'b0;
            wmask  <= '0;
            stage  <= '0;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (stop_det) begin
                commit <= !void_q && (wmask != '0);
                void_q <= 1'b1;
                pos    <= P_IDLE;
            end else if (start_det) begin
                pos    <= P_ADDR;
                void_q <= 1'b0;
                wmask  <= '0;
                accept <= 1'b0;
            end else if (byte_stb) begin
                accept <= 1'b1;
                case (pos)
                    P_ADDR: begin
                        accept <= addr_ok;
                        pos    <= addr_ok ? P_FIRST : P_IDLE;
                    end
                    P_FIRST, P_C1: begin
                        if (!byte_val[7] && pos == P_FIRST) begin
                            stage.ref_sel             <= byte_val[6:5];
                            stage.ratio[RATIO_W-1 -: HI_W] <= byte_val[HI_W-1:0];
                            wmask[G_D1] <= 1'b1;
                            pos         <= P_D2;
                        end else if (byte_val[7] && !byte_val[5]) begin
                            stage.loop_off <= byte_val[4];
                            stage.test_en  <= byte_val[3];
                            stage.pump_off <= byte_val[2];
                            stage.pump_cur <= byte_val[CUR_W-1:0];
                            wmask[G_C1]    <= 1'b1;
                            pos            <= P_C2;
                        end else begin
                            accept <= 1'b0;
                            void_q <= 1'b1;
                            pos    <= P_IDLE;
                        end
                    end
                    P_D2: begin
                        stage.ratio[2*SEG_W-1 -: SEG_W] <= byte_val[SEG_W-1:0];
                        wmask[G_D2] <= 1'b1;
                        pos         <= P_D3;
                    end
                    P_D3: begin
                        stage.ratio[SEG_W-1:0] <= byte_val[SEG_W-1:0];
                        wmask[G_D3] <= 1'b1;
                        pos         <= P_C1;
                    end
                    P_C2: begin
                        stage.dbl_off   <= byte_val[7];
                        stage.dbl_boost <= byte_val[6];
                        stage.sw        <= byte_val[SW_N-1:0];
                        wmask[G_C2]     <= 1'b1;
                        pos             <= P_C3;
                    end
                    P_C3: begin
                        if (byte_val[6:0] == '0) begin
                            pos <= P_END;
                        end else begin
                            accept <= 1'b0;
                            void_q <= 1'b1;
                            pos    <= P_IDLE;
                        end
                    end
                    P_END: begin
                        accept <= 1'b0;
                        void_q <= 1'b1;
                        pos    <= P_IDLE;
                    end
                    default: accept <= 1'b0;
                endcase
            end
        end
    end

    // R5: a commit request only ever follows a stop condition
    a_r5_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stop_det));
    // R1: the address position never acknowledges a wrong address
    a_r1_addr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && pos == P_ADDR && !addr_ok) |=> !accept);
endmodule

// File: rtl/tcfg_i2c_regs.sv
// Top of the I2C configuration write port: synchronizer, byte receiver and
// order sequencer, plus the live configuration registers that merge the
// staged groups on commit. Assumes an open-drain bus with external pull-up.
module tcfg_i2c_regs
    import tcfg_pkg::*;
#(
    parameter logic [4:0] ADDR_BASE   = 5'b11000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         addr_sel,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [RATIO_W-1:0] ratio,
    output logic [1:0]         ref_sel,
    output logic               loop_off,
    output logic               test_en,
    output logic               pump_off,
    output logic [CUR_W-1:0]   pump_cur,
    output logic               dbl_off,
    output logic               dbl_boost,
    output logic [SW_N-1:0]    sw_out,
    output logic               commit
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              accept, byte_stb, seq_commit;
    logic [BYTE_W-1:0] byte_val;
    logic [GRP_N-1:0]  wmask;
    cfg_t              stage, cfg_q, merged;

    tcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tcfg_byte_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .accept(accept), .byte_stb(byte_stb), .byte_val(byte_val),
        .sda_oe(sda_oe)
    );

    tcfg_frame_seq #(.ADDR_BASE(ADDR_BASE)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .byte_stb(byte_stb), .byte_val(byte_val), .addr_sel(addr_sel),
        .accept(accept), .stage(stage), .wmask(wmask), .commit(seq_commit)
    );

    // Purpose: overlay only the groups written in this transfer.
    always_comb begin
        merged = cfg_q;
        if (wmask[G_D1]) begin
            merged.ratio[RATIO_W-1 -: HI_W] = stage.ratio[RATIO_W-1 -: HI_W];
            merged.ref_sel                  = stage.ref_sel;
        end
        if (wmask[G_D2]) merged.ratio[2*SEG_W-1 -: SEG_W] = stage.ratio[2*SEG_W-1 -: SEG_W];
        if (wmask[G_D3]) merged.ratio[SEG_W-1:0] = stage.ratio[SEG_W-1:0];
        if (wmask[G_C1]) begin
            merged.loop_off = stage.loop_off;
            merged.test_en  = stage.test_en;
            merged.pump_off = stage.pump_off;
            merged.pump_cur = stage.pump_cur;
        end
        if (wmask[G_C2]) begin
            merged.dbl_off   = stage.dbl_off;
            merged.dbl_boost = stage.dbl_boost;
            merged.sw        = stage.sw;
        end
    end

    // Purpose: live configuration and the aligned commit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            commit <= 1'b0;
        end else begin
            commit <= seq_commit;
            if (seq_commit) cfg_q <= merged;
        end
    end

    assign ratio     = cfg_q.ratio;
    assign ref_sel   = cfg_q.ref_sel;
    assign loop_off  = cfg_q.loop_off;
    assign test_en   = cfg_q.test_en;
    assign pump_off  = cfg_q.pump_off;
    assign pump_cur  = cfg_q.pump_cur;
    assign dbl_off   = cfg_q.dbl_off;
    assign dbl_boost = cfg_q.dbl_boost;
    assign sw_out    = cfg_q.sw;

    // R5: live values hold unless a commit was requested
    a_r5_hold_between_commits: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_commit |=> $stable(cfg_q));
    // R5: the commit strobe is one cycle wide
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    // R10: no acknowledge while SCL-derived stop is seen
    a_r10_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

// File: tb/tcfg_i2c_regs_bench.sv
module tcfg_i2c_regs_bench;
    localparam int HP = 20;
    localparam int NV = 11;
    localparam logic [3:0] NONE = 4'hF;

    typedef struct packed {
        logic [7:0]  addr;
        logic [2:0]  n;
        logic [55:0] data;
        logic [3:0]  nack_at;
        logic        cmt;
        logic [29:0] exp;
    } vec_t;

    localparam logic [29:0] E0  = {15'b101101010010101, 2'b10, 3'b000, 2'b00, 2'b00, 6'b000000};
    localparam logic [29:0] E1  = {15'b101101010010101, 2'b10, 3'b101, 2'b10, 2'b10, 6'b110011};
    localparam logic [29:0] E2  = {15'b011101010010101, 2'b01, 3'b101, 2'b10, 2'b10, 6'b110011};
    localparam logic [29:0] E6  = {15'b111111111111111, 2'b10, 3'b000, 2'b01, 2'b01, 6'b001100};
    localparam logic [29:0] E10 = {15'b000010110111111, 2'b00, 3'b000, 2'b01, 2'b01, 6'b001100};

    localparam vec_t VT [NV] = '{
        '{8'hC4, 3'd3, {8'h45, 8'h2A, 8'h15, 32'h0},                   NONE, 1'b1, E0},
        '{8'hC4, 3'd3, {8'h96, 8'hB3, 8'h80, 32'h0},                   NONE, 1'b1, E1},
        '{8'hC4, 3'd1, {8'h33, 48'h0},                                 NONE, 1'b1, E2},
        '{8'hC4, 3'd4, {8'h45, 8'h2A, 8'h15, 8'h12, 24'h0},            4'd4, 1'b0, E2},
        '{8'hC4, 3'd1, {8'hA0, 48'h0},                                 4'd1, 1'b0, E2},
        '{8'hC4, 3'd3, {8'h9F, 8'hFF, 8'h01, 32'h0},                   4'd3, 1'b0, E2},
        '{8'hC4, 3'd6, {8'h47, 8'h3F, 8'h3F, 8'h81, 8'h4C, 8'h00, 8'h0}, NONE, 1'b1, E6},
        '{8'hC4, 3'd7, {8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 8'h00}, 4'd7, 1'b0, E6},
        '{8'hC6, 3'd1, {8'h45, 48'h0},                                 4'd0, 1'b0, E6},
        '{8'hC5, 3'd1, {8'h45, 48'h0},                                 4'd0, 1'b0, E6},
        '{8'hC4, 3'd2, {8'h00, 8'h96, 40'h0},                          NONE, 1'b1, E10}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] addr_sel = 2'b10;
    logic scl = 1'b1, sda_drv = 1'b1, sda_line;
    logic sda_oe, loop_off, test_en, pump_off, dbl_off, dbl_boost, commit;
    logic [14:0] ratio;
    logic [1:0]  ref_sel, pump_cur;
    logic [5:0]  sw_out;
    logic [29:0] got;
    int tests = 0, fails = 0, commits = 0;
    bit done = 0;

    always #4 clk = ~clk;
    assign sda_line = sda_drv & ~sda_oe;
    assign got = {ratio, ref_sel, loop_off, test_en, pump_off, pump_cur, dbl_off, dbl_boost, sw_out};

    tcfg_i2c_regs u_tcfg_i2c_regs (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .ratio(ratio), .ref_sel(ref_sel), .loop_off(loop_off),
        .test_en(test_en), .pump_off(pump_off), .pump_cur(pump_cur), .dbl_off(dbl_off),
        .dbl_boost(dbl_boost), .sw_out(sw_out), .commit(commit)
    );

    always @(negedge clk) if (rst_n && commit) commits++;

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic i2c_start();
        sda_drv = 1'b1; wt(HP); scl = 1'b1; wt(HP);
        sda_drv = 1'b0; wt(HP); scl = 1'b0; wt(6);
    endtask

    task automatic i2c_stop();
        sda_drv = 1'b0; wt(HP); scl = 1'b1; wt(HP); sda_drv = 1'b1; wt(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wt(HP); scl = 1'b1; wt(HP); scl = 1'b0; wt(6);
        end
        sda_drv = 1'b1; wt(HP); scl = 1'b1; wt(HP / 2);
        acked = (sda_line == 1'b0);
        wt(HP / 2); scl = 1'b0; wt(6);
    endtask

    task automatic xfer(input logic [7:0] addr, input int n, input logic [55:0] data,
                        input bit do_stop, output logic [3:0] nack_at);
        logic a;
        nack_at = NONE;
        i2c_start();
        send_byte(addr, a);
        if (!a) nack_at = 4'd0;
        for (int k = 0; k < n && nack_at == NONE; k++) begin
            send_byte(data[55 - 8*k -: 8], a);
            if (!a) nack_at = 4'(k + 1);
        end
        if (do_stop) begin i2c_stop(); wt(10); end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0: return "R2";       1: return "R3 R4";   2: return "R7";
            3: return "R8";       4: return "R9";      5: return "R9";
            6: return "R10";      7: return "R9";      8: return "R1";
            9: return "R1";       default: return "R6";
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] nk;
        int c0;
        wt(5); rst_n = 1'b1; wt(3);
        // R11: reset state
        chk("R11 cfg", 32'(got), 32'h0);
        chk("R11 sda", 32'(sda_oe), 32'h0);
        chk("R11 commit", 32'(commit), 32'h0);

        for (int i = 0; i < NV; i++) begin
            c0 = commits;
            xfer(VT[i].addr, int'(VT[i].n), VT[i].data, 1'b1, nk);
            chk({tag_of(i), " ack"}, 32'(nk), 32'(VT[i].nack_at));
            chk({tag_of(i), " R5 commit"}, 32'(commits - c0), 32'(VT[i].cmt));
            chk({tag_of(i), " cfg"}, 32'(got), 32'(VT[i].exp));
        end

        // R5: nothing visible before stop, one pulse after
        c0 = commits;
        xfer(8'hC4, 3, {8'h00, 8'h00, 8'h00, 32'h0}, 1'b0, nk);
        wt(20);
        chk("R5 held", 32'(got), 32'(E10));
        chk("R5 no early pulse", 32'(commits - c0), 32'h0);
        i2c_stop(); wt(10);
        chk("R5 pulse", 32'(commits - c0), 32'h1);
        chk("R5 ratio", 32'(ratio), 32'h0);

        // R12: repeated start drops staged divider byte
        i2c_start();
        send_byte(8'hC4, nk[0]);
        send_byte(8'h7F, nk[0]);
        xfer(8'hC4, 1, {8'h80, 48'h0}, 1'b1, nk);
        chk("R12 ratio", 32'(ratio), 32'h0);
        chk("R12 ref", 32'(ref_sel), 32'h0);
        chk("R12 ctrl", 32'({loop_off, test_en, pump_off, pump_cur}), 32'h0);

        // R1: other address select
        addr_sel = 2'b01;
        xfer(8'hC2, 2, {8'h80, 8'h3F, 40'h0}, 1'b1, nk);
        chk("R1 sel ack", 32'(nk), 32'(NONE));
        chk("R4 sw", 32'({dbl_off, dbl_boost, sw_out}), 32'h03F);
        xfer(8'hC4, 1, {8'h96, 48'h0}, 1'b1, nk);
        chk("R1 old addr nack", 32'(nk), 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule